// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose 12-bit down-counter runs on its own low-speed clock rather than the bus clock, so it keeps counting if the main clock stops. Software reaches it only through a small register port in the bus clock domain. The centre of that port is a 16-bit command register that accepts three special code words. One code starts the countdown. One copies the reload value into the counter. One opens the prescaler and reload registers for writing. When the counter reaches zero while the watchdog runs, the block raises a reset request.

Commands and configuration cross into the counter clock domain through toggle flags and two-stage synchronizers. Acknowledge toggles come back the same way and drive two pending status bits. A strap input can make the watchdog run from power-up with no start command. Once running, the watchdog can only be stopped by the system reset. That reset also clears the reset request, which otherwise stays high.

Top module: `kwdt_top`

## Requirements
- R1: After system reset the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0 and `wd_reset_req` is low.
- R2: With `hw_opt` low and no 0xCCCC command, the counter does not run and no reset request appears. Writing 0xCCCC to the command register (offset 0) starts the countdown.
- R3: Writing 0xAAAA to the command register loads the reload value into the counter and restarts the prescaler. Refreshes spaced closer than the timeout keep `wd_reset_req` low.
- R4: A running counter decrements once per prescaled tick. `wd_reset_req` rises when the counter is zero, about reload × divide counter-clock cycles after a refresh, plus a few cycles of crossing delay.
- R5: Writes to the prescaler (offset 1, bits [2:0]) and reload (offset 2, bits [11:0]) registers are ignored unless 0x5555 has been written to the command register.
- R6: Any command value other than 0xCCCC, 0xAAAA or 0x5555 closes write access to the prescaler and reload registers again.
- R7: The divide ratio is 4 × 2^P for a prescaler value P from 0 to 6. Values 7 and above divide by 256.
- R8: With `hw_opt` high the counter runs without a start command and still raises the reset request unless refreshed.
- R9: No command value stops a running watchdog.
- R10: Once high, `wd_reset_req` stays high until the system reset, and refresh commands do not clear it.
- R11: Status register (offset 3) bit 0 shows a prescaler update still crossing and bit 1 a reload update still crossing. A write to a register whose update is still pending is dropped.
- R12: The command register reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| wd_clk | input | 1 | Independent low-speed counter clock |
| sys_rst_n | input | 1 | Active-low system reset, asynchronous, both domains |
| hw_opt | input | 1 | Strap: run the watchdog from power-up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register offset |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| wd_reset_req | output | 1 | Reset request, held until system reset |

## Verification
The assertions assume that `hw_opt` is a static strap that does not change between system resets. They also assume that a new prescaler or reload value is only followed by a refresh once the pending bits have cleared, so the counter domain never loads a value that is still crossing. The stimulus changes `hw_opt` only while reset is held. After every configuration it polls the status register until it reads zero, and it spaces refresh commands several counter-clock cycles apart so each toggle crosses on its own.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int CNT_W   = 12;
    localparam int PR_W    = 3;

    localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_RELOAD = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;

    localparam logic [ADDR_W-1:0] OFS_KEY  = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_PR   = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_RLR  = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd3;
endpackage

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/kwdt_bus_regs.sv
module kwdt_bus_regs
    import kwdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        ack_sync,
    output logic [DATA_W-1:0] rd_data,
    output logic [PW-1:0]     pr_val,
    output logic [CW-1:0]     rlr_val,
    output logic              start_lvl,
    output logic              rfs_tog,
    output logic              pr_tog,
    output logic              rlr_tog,
    output logic              unlocked,
    output logic [1:0]        pend
);
    typedef struct packed {
        logic          open;
        logic          started;
        logic          rfs_t;
        logic          pr_t;
        logic          rlr_t;
        logic [PW-1:0] pr;
        logic [CW-1:0] rlr;
    } bus_st_t;

    bus_st_t st_q, st_d;
    logic [1:0] pend_c;

    always_comb begin
        st_d   = st_q;
        pend_c = {st_q.rlr_t ^ ack_sync[1], st_q.pr_t ^ ack_sync[0]};
        if (wr_en) begin
            unique case (wr_addr)
                OFS_KEY: begin
                    if (wr_data == KEY_START)       st_d.started = 1'b1;
                    else if (wr_data == KEY_RELOAD) st_d.rfs_t   = ~st_q.rfs_t;
                    else if (wr_data == KEY_UNLOCK) st_d.open    = 1'b1;
                    else                            st_d.open    = 1'b0;
                end
                OFS_PR: if (st_q.open && !pend_c[0]) begin
                    st_d.pr   = wr_data[PW-1:0];
                    st_d.pr_t = ~st_q.pr_t;
                end
                OFS_RLR: if (st_q.open && !pend_c[1]) begin
                    st_d.rlr   = wr_data[CW-1:0];
                    st_d.rlr_t = ~st_q.rlr_t;
                end
                default: ;
            endcase
        end
        unique case (rd_addr)
            OFS_PR:   rd_data = DATA_W'(st_q.pr);
            OFS_RLR:  rd_data = DATA_W'(st_q.rlr);
            OFS_STAT: rd_data = DATA_W'(pend_c);
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rlr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pr_val    = st_q.pr;
    assign rlr_val   = st_q.rlr;
    assign start_lvl = st_q.started;
    assign rfs_tog   = st_q.rfs_t;
    assign pr_tog    = st_q.pr_t;
    assign rlr_tog   = st_q.rlr_t;
    assign unlocked  = st_q.open;
    assign pend      = pend_c;
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
    parameter int CW       = 12,
    parameter int PW       = 3,
    parameter int DIV_BASE = 4,
    parameter int PR_MAX   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_opt,
    input  logic          start_s,
    input  logic          rfs_s,
    input  logic          pr_s,
    input  logic          rlr_s,
    input  logic [PW-1:0] pr_bus,
    input  logic [CW-1:0] rlr_bus,
    output logic [1:0]    ack,
    output logic          running,
    output logic [CW-1:0] cnt,
    output logic          tick,
    output logic          reload_evt,
    output logic          rst_req
);
    localparam int DIV_W = $clog2(DIV_BASE) + PR_MAX;

    typedef struct packed {
        logic             run;
        logic             rfs_seen;
        logic             pr_seen;
        logic             rlr_seen;
        logic [PW-1:0]    pr;
        logic [CW-1:0]    rlr;
        logic [DIV_W-1:0] div;
        logic [CW-1:0]    cnt;
        logic             rst;
    } core_st_t;

    core_st_t st_q, st_d;
    logic [PW-1:0]    pr_eff;
    logic [DIV_W:0]   ratio;
    logic [DIV_W-1:0] ratio_m1;
    logic             tick_c, rfs_evt;

    always_comb begin
        st_d     = st_q;
        pr_eff   = (st_q.pr > PW'(PR_MAX)) ? PW'(PR_MAX) : st_q.pr;
        ratio    = (DIV_W+1)'(DIV_BASE) << pr_eff;
        ratio_m1 = DIV_W'(ratio - 1'b1);
        tick_c   = st_q.run && (st_q.div == ratio_m1);
        rfs_evt  = rfs_s ^ st_q.rfs_seen;

        st_d.rfs_seen = rfs_s;
        if (pr_s != st_q.pr_seen) begin
            st_d.pr      = pr_bus;
            st_d.pr_seen = pr_s;
        end
        if (rlr_s != st_q.rlr_seen) begin
            st_d.rlr      = rlr_bus;
            st_d.rlr_seen = rlr_s;
        end

        st_d.run = st_q.run | start_s | hw_opt;
        if (st_q.run) st_d.div = tick_c ? '0 : st_q.div + 1'b1;

        if (rfs_evt) begin
            st_d.cnt = st_q.rlr;
            st_d.div = '0;
        end else if (tick_c && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end

        st_d.rst = st_q.rst | (st_q.run && st_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rlr <= '1;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack        = {st_q.rlr_seen, st_q.pr_seen};
    assign running    = st_q.run;
    assign cnt        = st_q.cnt;
    assign tick       = tick_c;
    assign reload_evt = rfs_evt;
    assign rst_req    = st_q.rst;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              wd_clk,
    input  logic              sys_rst_n,
    input  logic              hw_opt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wd_reset_req
);
    logic [PR_W-1:0]  bus_pr;
    logic [CNT_W-1:0] bus_rlr;
    logic             bus_unlocked;
    logic [1:0]       bus_pend, ack_bus, ack_wd;
    logic             start_lvl, rfs_tog, pr_tog, rlr_tog;
    logic [3:0]       fwd_sync;
    logic             wd_running, wd_tick, wd_reload_evt;
    logic [CNT_W-1:0] wd_cnt;

    kwdt_bus_regs #(.CW(CNT_W), .PW(PR_W)) u_bus (
        .clk(bus_clk), .rst_n(sys_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .ack_sync(ack_bus), .rd_data(rd_data),
        .pr_val(bus_pr), .rlr_val(bus_rlr),
        .start_lvl(start_lvl), .rfs_tog(rfs_tog), .pr_tog(pr_tog), .rlr_tog(rlr_tog),
        .unlocked(bus_unlocked), .pend(bus_pend)
    );

    kwdt_sync #(.W(4), .STAGES(SYNC_STAGES)) u_fwd (
        .clk(wd_clk), .rst_n(sys_rst_n),
        .din({rlr_tog, pr_tog, rfs_tog, start_lvl}), .dout(fwd_sync)
    );

    kwdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_back (
        .clk(bus_clk), .rst_n(sys_rst_n), .din(ack_wd), .dout(ack_bus)
    );

    kwdt_core #(.CW(CNT_W), .PW(PR_W)) u_core (
        .clk(wd_clk), .rst_n(sys_rst_n), .hw_opt(hw_opt),
        .start_s(fwd_sync[0]), .rfs_s(fwd_sync[1]), .pr_s(fwd_sync[2]), .rlr_s(fwd_sync[3]),
        .pr_bus(bus_pr), .rlr_bus(bus_rlr), .ack(ack_wd),
        .running(wd_running), .cnt(wd_cnt), .tick(wd_tick),
        .reload_evt(wd_reload_evt), .rst_req(wd_reset_req)
    );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
(
    input logic              bus_clk,
    input logic              wd_clk,
    input logic              sys_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              bus_unlocked,
    input logic [1:0]        bus_pend,
    input logic [PR_W-1:0]   bus_pr,
    input logic [CNT_W-1:0]  bus_rlr,
    input logic              wd_running,
    input logic              wd_tick,
    input logic              wd_reload_evt,
    input logic [CNT_W-1:0]  wd_cnt,
    input logic              wd_reset_req
);
    // R10
    rst_sticky_chk: assert property (@(posedge wd_clk) disable iff (!sys_rst_n)
        wd_reset_req |=> wd_reset_req);
    // R4
    rst_needs_run_chk: assert property (@(posedge wd_clk) disable iff (!sys_rst_n)
        $rose(wd_reset_req) |-> wd_running);
    // R9
    run_sticky_chk: assert property (@(posedge wd_clk) disable iff (!sys_rst_n)
        wd_running |=> wd_running);
    // R4
    cnt_dec_chk: assert property (@(posedge wd_clk) disable iff (!sys_rst_n)
        (wd_running && wd_tick && !wd_reload_evt && wd_cnt != '0)
        |=> wd_cnt == CNT_W'($past(wd_cnt) - 1'b1));
    // R2
    idle_cnt_chk: assert property (@(posedge wd_clk) disable iff (!sys_rst_n)
        (!wd_running && !wd_reload_evt) |=> $stable(wd_cnt));
    // R5
    locked_pr_chk: assert property (@(posedge bus_clk) disable iff (!sys_rst_n)
        (wr_en && wr_addr == OFS_PR && !bus_unlocked) |=> $stable(bus_pr));
    // R5
    locked_rlr_chk: assert property (@(posedge bus_clk) disable iff (!sys_rst_n)
        (wr_en && wr_addr == OFS_RLR && !bus_unlocked) |=> $stable(bus_rlr));
    // R11
    pend_drop_chk: assert property (@(posedge bus_clk) disable iff (!sys_rst_n)
        (wr_en && wr_addr == OFS_RLR && bus_pend[1]) |=> $stable(bus_rlr));
endmodule

bind kwdt_top kwdt_checker u_chk (
    .bus_clk(bus_clk), .wd_clk(wd_clk), .sys_rst_n(sys_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .bus_unlocked(bus_unlocked),
    .bus_pend(bus_pend), .bus_pr(bus_pr), .bus_rlr(bus_rlr),
    .wd_running(wd_running), .wd_tick(wd_tick), .wd_reload_evt(wd_reload_evt),
    .wd_cnt(wd_cnt), .wd_reset_req(wd_reset_req)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_PERIOD  = 30;
    localparam int LIMIT_NS   = 1500000;

    logic        bus_clk = 0, wd_clk = 0, sys_rst_n = 0, hw_opt = 0, wr_en = 0;
    logic [1:0]  wr_addr = 0, rd_addr = 0;
    logic [15:0] wr_data = 0, rd_data;
    logic        wd_reset_req;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
    always #(WD_PERIOD/2)  wd_clk  = ~wd_clk;

    kwdt_top dut (.bus_clk(bus_clk), .wd_clk(wd_clk), .sys_rst_n(sys_rst_n), .hw_opt(hw_opt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wd_reset_req(wd_reset_req));

    function automatic int exp_ratio(int p);
        return (p >= 6) ? 256 : (4 << p);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge bus_clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge bus_clk); wr_en = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge bus_clk); rd_addr = a; #1 d = rd_data;
    endtask

    task automatic wdw(int n);
        repeat (n) @(posedge wd_clk);
        @(negedge wd_clk);
    endtask

    task automatic do_reset(bit opt);
        @(negedge bus_clk); sys_rst_n = 0; hw_opt = opt;
        wdw(3);
        @(negedge bus_clk); sys_rst_n = 1;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 100; i++) begin
            rd(2'd3, s);
            if (s == 0) break;
        end
    endtask

    task automatic cfg(int p, int r);
        wr(2'd0, 16'h5555); wr(2'd1, 16'(p)); wr(2'd2, 16'(r));
        wait_idle();
    endtask

    task automatic timeout_win(string req, int expc);
        wdw(expc - 2);
        check(wd_reset_req == 0, req, wd_reset_req, 0);
        wdw(12);
        check(wd_reset_req == 1, req, wd_reset_req, 1);
    endtask

    initial begin
        #(LIMIT_NS);
        n_fail++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd7321));
        do_reset(0);
        // R1 reset state
        rd(2'd1, v); check(v == 0, "R1 pr", v, 0);
        rd(2'd2, v); check(v == 16'hFFF, "R1 rlr", v, 16'hFFF);
        rd(2'd3, v); check(v == 0, "R1 status", v, 0);
        check(wd_reset_req == 0, "R1 req", wd_reset_req, 0);
        // R12 key reads 0
        wr(2'd0, 16'h1234); rd(2'd0, v); check(v == 0, "R12 key read", v, 0);
        // R5 locked writes ignored
        wr(2'd1, 16'd3); wr(2'd2, 16'd77);
        rd(2'd1, v); check(v == 0, "R5 pr locked", v, 0);
        rd(2'd2, v); check(v == 16'hFFF, "R5 rlr locked", v, 16'hFFF);
        cfg(2, 10);
        rd(2'd1, v); check(v == 2, "R5 pr unlocked", v, 2);
        rd(2'd2, v); check(v == 10, "R5 rlr unlocked", v, 10);
        // R6 relock by foreign key
        wr(2'd0, 16'h0F0F); wr(2'd1, 16'd5); wait_idle();
        rd(2'd1, v); check(v == 2, "R6 relock", v, 2);
        // R11 pending drop
        wr(2'd0, 16'h5555);
        @(negedge bus_clk); wr_en = 1; wr_addr = 2; wr_data = 16'd50;
        @(negedge bus_clk); wr_data = 16'd60;
        @(negedge bus_clk); wr_en = 0;
        rd(2'd3, v); check(v == 16'h2, "R11 pending bit", v, 2);
        rd(2'd2, v); check(v == 50, "R11 drop", v, 50);
        wait_idle(); rd(2'd3, v); check(v == 0, "R11 cleared", v, 0);
        // R2 not started: no reset
        cfg(0, 5); wr(2'd0, 16'hAAAA); wdw(300);
        check(wd_reset_req == 0, "R2 idle", wd_reset_req, 0);
        wr(2'd0, 16'hCCCC); wdw(40);
        check(wd_reset_req == 1, "R2 start", wd_reset_req, 1);
        // R10 sticky
        wr(2'd0, 16'hAAAA); wdw(60);
        check(wd_reset_req == 1, "R10 sticky", wd_reset_req, 1);
        do_reset(0);
        check(wd_reset_req == 0, "R10 cleared", wd_reset_req, 0);
        // R3 and R9 random refreshes plus foreign keys
        cfg(0, 40); wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
        for (int i = 0; i < 25; i++) begin
            int gap = 20 + int'($urandom % 110);
            logic [15:0] k = 16'($urandom);
            wdw(gap);
            if (k != 16'hCCCC && k != 16'hAAAA && k != 16'h5555) wr(2'd0, k);
            wr(2'd0, 16'hAAAA);
            check(wd_reset_req == 0, "R3 refreshed", wd_reset_req, 0);
        end
        wr(2'd0, 16'h0000);
        timeout_win("R9 no stop", 160);
        // R4 and R7 directed prescaler values
        do_reset(0); cfg(2, 10); wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
        timeout_win("R4 pr2", 10 * exp_ratio(2));
        do_reset(0); cfg(7, 2); wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
        timeout_win("R7 pr7", 2 * exp_ratio(7));
        // R7 random prescaler values
        for (int t = 0; t < 4; t++) begin
            int p = int'($urandom % 8);
            do_reset(0); cfg(p, 3); wr(2'd0, 16'hCCCC); wr(2'd0, 16'hAAAA);
            timeout_win("R7 random pr", 3 * exp_ratio(p));
        end
        // R8 strap runs without start key
        do_reset(1); cfg(0, 6); wr(2'd0, 16'hAAAA);
        timeout_win("R8 strap", 24);
        do_reset(0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule